// File: doc/BRIEF.md
# Per-channel gain/offset calibration with deferred output load

This block holds, for a bank of converter channels, a raw 14-bit code, a 13-bit gain and a 14-bit offset per channel. Whenever any of those three values is written, a small engine recomputes that channel's calibrated code as `code × (gain + 1) / 2^13 + offset − 2^13`. It works at full precision and clamps the result into the 14-bit range. The result is held in a staging register and is not seen at the outputs yet.

The staged codes move into the output registers only on a load. A load comes from a falling edge of the active-low load input, or from that input being held low. A load waits until the block is no longer busy. Busy is raised by the block itself while work is pending, or by an external device pulling the shared busy line low. An active-low clear input forces every channel into the cleared indication and blocks loads. The stored registers keep their contents, and channels stay cleared until the next load after clear is released. On a load, only channels whose staged code differs from the current output are rewritten, and each rewrite is flagged by a one-cycle strobe.

The engine is a three-state machine: `ENG_IDLE`, `ENG_MUL` and `ENG_SAT`. It goes from `ENG_IDLE` to `ENG_MUL` when any channel is marked dirty; the lowest-numbered dirty channel is taken first. It goes from `ENG_MUL` to `ENG_SAT` unconditionally. It goes from `ENG_SAT` back to `ENG_IDLE` while writing the staged result. The output stage has two states, `OUT_CLR` and `OUT_RUN`. It goes from any state to `OUT_CLR` while clear is low. It goes from `OUT_CLR` to `OUT_RUN` on a load. It stays in `OUT_RUN` otherwise.

Top module: `calib_loader`

## Requirements
- R1: After reset, every output code is 0x2000, every clear indication is 1 and `busy_n` is 1. The reset values are raw code 0x2000, gain 0x1FFF and offset 0x2000, so each staged code is also 0x2000.
- R2: A write targets the register selected by `wr_sel`: 0 = raw code, 1 = gain (low 13 bits of `wr_data`), 2 = offset. `wr_sel` = 3, or a channel index at or above NUM_CH, changes nothing and starts no computation.
- R3: The staged code equals floor(code × (gain + 1) / 8192) + offset − 8192. With the reset gain and offset, this is the raw code itself.
- R4: A staged result above 16383 is clamped to 16383, and a result below 0 is clamped to 0.
- R5: `busy_n` goes low in the cycle after an accepted write. It returns high three clock edges later, once that channel's result is staged, if no other work is pending.
- R6: A falling edge on `load_n` that occurs while busy is remembered. The outputs are loaded as soon as busy is released, with no further edge needed.
- R7: While `load_n` is held low, the outputs take each newly staged code once busy is released.
- R8: `upd_stb[i]` pulses for one cycle exactly when a load rewrites channel i, which happens only if its staged code differs from its output code.
- R9: While `clr_n` is low, `out_clr` is all ones and loads (edges or level) have no effect. The output and staged registers keep their values. After `clr_n` rises, `out_clr` stays high until the next load.
- R10: While `busy_ext_n` is low, no load takes place. A pending load completes after it rises.
- R11: Without a load, a newly staged code does not change `out_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 code, 1 gain, 2 offset, 3 none |
| wr_ch | input | CHW | Channel index of the write |
| wr_data | input | DW | Write data |
| load_n | input | 1 | Active-low load request (edge or level) |
| clr_n | input | 1 | Active-low clear |
| busy_ext_n | input | 1 | Shared busy line as seen from outside; low delays loads |
| busy_n | output | 1 | Active-low busy drive of this block |
| out_code | output | NUM_CH*DW | Output code registers, channel 0 in the low bits |
| out_clr | output | NUM_CH | Per-channel cleared indication |
| upd_stb | output | NUM_CH | One-cycle strobe per rewritten output register |

## Verification
The bench builds the block with NUM_CH = 4. This is small enough to compare every channel after each load, and large enough that a load can change one channel while three others remain unchanged, which exercises the rewrite-only-on-change strobes. The data widths stay at their default 14/13 bits. This lets the bench reach both saturation limits with real offsets and the identity case of the reset gain, using hand-computed codes. Separate phases hold the external busy line low, keep the load input low, and assert clear, so that deferred, level-driven and blocked loads each get their own expected outcomes.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [1:0] {
        SEL_CODE = 2'd0,
        SEL_GAIN = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_MUL  = 2'd1,
        ENG_SAT  = 2'd2
    } eng_state_e;

    typedef enum logic {
        OUT_CLR = 1'b0,
        OUT_RUN = 1'b1
    } out_state_e;

endpackage

// File: rtl/calib_regs.sv
module calib_regs
    import calib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 14,
    parameter int GW     = 13,
    parameter int CHW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [DW-1:0]     wr_data,
    input  logic [CHW-1:0]    rd_ch,
    output logic [DW-1:0]     rd_code,
    output logic [GW-1:0]     rd_gain,
    output logic [DW-1:0]     rd_offs,
    input  logic [NUM_CH-1:0] dirty_clr,
    output logic [NUM_CH-1:0] dirty
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [DW-1:0] code_r [NUM_CH];
    logic [GW-1:0] gain_r [NUM_CH];
    logic [DW-1:0] offs_r [NUM_CH];
    wsel_e         sel;

    assign sel = wsel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                code_r[i] <= MID;
                gain_r[i] <= '1;
                offs_r[i] <= MID;
            end
            dirty <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_en && (wr_ch == CHW'(i)) && (sel != SEL_NONE)) begin
                    unique case (sel)
                        SEL_CODE: code_r[i] <= wr_data;
                        SEL_GAIN: gain_r[i] <= wr_data[GW-1:0];
                        SEL_OFFS: offs_r[i] <= wr_data;
                        default:  ;
                    endcase
                    dirty[i] <= 1'b1;
                end else if (dirty_clr[i]) begin
                    dirty[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_code = code_r[rd_ch];
    assign rd_gain = gain_r[rd_ch];
    assign rd_offs = offs_r[rd_ch];

    // R2
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE) |=> ((dirty & ~$past(dirty)) == '0));

endmodule

// File: rtl/calib_engine.sv
module calib_engine
    import calib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 14,
    parameter int GW     = 13,
    parameter int CHW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] dirty,
    output logic [CHW-1:0]    rd_ch,
    input  logic [DW-1:0]     rd_code,
    input  logic [GW-1:0]     rd_gain,
    input  logic [DW-1:0]     rd_offs,
    output logic [NUM_CH-1:0] dirty_clr,
    output logic              res_we,
    output logic [CHW-1:0]    res_ch,
    output logic [DW-1:0]     res_val,
    output logic              busy
);
    localparam int PW = DW + GW;
    localparam int SW = DW + 2;
    localparam logic signed [SW-1:0] BIAS = SW'(1) << (DW - 1);

    eng_state_e state, state_nx;
    logic [CHW-1:0] cur_ch, pick_ch;
    logic           pick_ok;
    logic [PW-1:0]  prod_q;
    logic [DW-1:0]  offs_q;
    logic [GW:0]    gain_p1;
    logic [DW-1:0]  scaled;
    logic signed [SW-1:0] sum_s;

    // lowest dirty channel wins
    always_comb begin
        pick_ch = '0;
        pick_ok = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (dirty[i]) begin
                pick_ch = CHW'(i);
                pick_ok = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE: if (pick_ok) state_nx = ENG_MUL;
            ENG_MUL:  state_nx = ENG_SAT;
            ENG_SAT:  state_nx = ENG_IDLE;
            default:  state_nx = ENG_IDLE;
        endcase
    end

    assign gain_p1 = {1'b0, rd_gain} + (GW + 1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch <= '0;
            prod_q <= '0;
            offs_q <= '0;
        end else begin
            if (state == ENG_IDLE && pick_ok) cur_ch <= pick_ch;
            if (state == ENG_MUL) begin
                prod_q <= PW'(rd_code) * PW'(gain_p1);
                offs_q <= rd_offs;
            end
        end
    end

    assign scaled = prod_q[PW-1:GW];
    assign sum_s  = $signed({2'b00, scaled}) + $signed({2'b00, offs_q}) - BIAS;

    // outputs
    always_comb begin
        rd_ch     = cur_ch;
        res_ch    = cur_ch;
        res_we    = (state == ENG_SAT);
        dirty_clr = '0;
        if (state == ENG_IDLE && pick_ok) dirty_clr[pick_ch] = 1'b1;
        if (sum_s[SW-1])      res_val = '0;
        else if (sum_s[DW])   res_val = '1;
        else                  res_val = sum_s[DW-1:0];
        busy = (state != ENG_IDLE) || (|dirty);
    end

    // R5
    start_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE && |dirty) |=> (state == ENG_MUL));

    // R5
    mul_to_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_MUL) |=> (state == ENG_SAT));

endmodule

// File: rtl/calib_outreg.sv
module calib_outreg
    import calib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 14,
    parameter int CHW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_we,
    input  logic [CHW-1:0]       res_ch,
    input  logic [DW-1:0]        res_val,
    input  logic                 busy_all,
    input  logic                 load_n,
    input  logic                 clr_n,
    output logic [NUM_CH*DW-1:0] dac_flat,
    output logic [NUM_CH-1:0]    upd_stb,
    output logic                 cleared
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    out_state_e    ostate, ostate_nx;
    logic [DW-1:0] stage_r [NUM_CH];
    logic [DW-1:0] dac_r   [NUM_CH];
    logic          load_q, ld_pend, do_load;

    assign do_load = clr_n && !busy_all && (ld_pend || !load_n);

    always_ff @(posedge clk) begin
        if (!rst_n) ostate <= OUT_CLR;
        else        ostate <= ostate_nx;
    end

    always_comb begin
        ostate_nx = ostate;
        if (!clr_n) ostate_nx = OUT_CLR;
        else begin
            unique case (ostate)
                OUT_CLR: if (do_load) ostate_nx = OUT_RUN;
                OUT_RUN: ostate_nx = OUT_RUN;
                default: ostate_nx = OUT_CLR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b1;
            ld_pend <= 1'b0;
        end else begin
            load_q <= load_n;
            if (!clr_n || do_load)      ld_pend <= 1'b0;
            else if (load_q && !load_n) ld_pend <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                stage_r[i] <= MID;
                dac_r[i]   <= MID;
            end
            upd_stb <= '0;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (res_we && res_ch == CHW'(i)) stage_r[i] <= res_val;
                upd_stb[i] <= do_load && (stage_r[i] != dac_r[i]);
                if (do_load && stage_r[i] != dac_r[i]) dac_r[i] <= stage_r[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) dac_flat[i*DW +: DW] = dac_r[i];
        cleared = (ostate == OUT_CLR);
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R8
        upd_changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            upd_stb[g] |-> (dac_r[g] != $past(dac_r[g])));
    end

    // R6
    hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_all |=> $stable(dac_flat));

    // R9
    clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> ($stable(dac_flat) && cleared));

endmodule

// File: rtl/calib_loader.sv
module calib_loader
    import calib_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DW     = 14,
    parameter int GW     = 13,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CHW-1:0]       wr_ch,
    input  logic [DW-1:0]        wr_data,
    input  logic                 load_n,
    input  logic                 clr_n,
    input  logic                 busy_ext_n,
    output logic                 busy_n,
    output logic [NUM_CH*DW-1:0] out_code,
    output logic [NUM_CH-1:0]    out_clr,
    output logic [NUM_CH-1:0]    upd_stb
);
    logic              wr_ok;
    logic [CHW-1:0]    rd_ch, res_ch;
    logic [DW-1:0]     rd_code, rd_offs, res_val;
    logic [GW-1:0]     rd_gain;
    logic [NUM_CH-1:0] dirty, dirty_clr;
    logic              res_we, eng_busy, busy_all, cleared;

    assign wr_ok    = wr_en && (32'(wr_ch) < NUM_CH);
    assign busy_all = eng_busy || !busy_ext_n;
    assign busy_n   = !eng_busy;
    assign out_clr  = {NUM_CH{cleared}};

    calib_regs #(.NUM_CH(NUM_CH), .DW(DW), .GW(GW), .CHW(CHW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_sel(wr_sel),
        .wr_ch(wr_ch), .wr_data(wr_data), .rd_ch(rd_ch),
        .rd_code(rd_code), .rd_gain(rd_gain), .rd_offs(rd_offs),
        .dirty_clr(dirty_clr), .dirty(dirty)
    );

    calib_engine #(.NUM_CH(NUM_CH), .DW(DW), .GW(GW), .CHW(CHW)) u_eng (
        .clk(clk), .rst_n(rst_n), .dirty(dirty), .rd_ch(rd_ch),
        .rd_code(rd_code), .rd_gain(rd_gain), .rd_offs(rd_offs),
        .dirty_clr(dirty_clr), .res_we(res_we), .res_ch(res_ch),
        .res_val(res_val), .busy(eng_busy)
    );

    calib_outreg #(.NUM_CH(NUM_CH), .DW(DW), .CHW(CHW)) u_out (
        .clk(clk), .rst_n(rst_n), .res_we(res_we), .res_ch(res_ch),
        .res_val(res_val), .busy_all(busy_all), .load_n(load_n),
        .clr_n(clr_n), .dac_flat(out_code), .upd_stb(upd_stb),
        .cleared(cleared)
    );

    // R10
    ext_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_ext_n |=> (upd_stb == '0));

endmodule

// File: tb/calib_loader_tb.sv
`timescale 1ns/1ps
module calib_loader_tb;
    localparam int N  = 4;
    localparam int DW = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [1:0] wr_ch = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic load_n = 1'b1, clr_n = 1'b1, busy_ext_n = 1'b1;
    logic busy_n;
    logic [N*DW-1:0] out_code;
    logic [N-1:0] out_clr, upd_stb;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [N-1:0] upd_seen = '0;

    int mx1 [N], mg [N], mo [N], exp_out [N];
    logic [N-1:0] exp_mask;

    typedef struct { int ch; int code; string tag; } item_t;
    item_t sb [$];

    calib_loader #(.NUM_CH(N), .DW(DW), .GW(13)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_ch(wr_ch), .wr_data(wr_data), .load_n(load_n), .clr_n(clr_n),
        .busy_ext_n(busy_ext_n), .busy_n(busy_n), .out_code(out_code),
        .out_clr(out_clr), .upd_stb(upd_stb)
    );

    always #2 clk = ~clk;

    always @(negedge clk) upd_seen <= upd_seen | upd_stb;

    function automatic int calc(int ch);
        int s;
        s = ((mx1[ch] * (mg[ch] + 1)) >> 13) + mo[ch] - 8192;
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return s;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int sel, int ch, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_ch = 2'(ch); wr_data = DW'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel == 0) mx1[ch] = data;
        if (sel == 1) mg[ch] = data & 16'h1FFF;
        if (sel == 2) mo[ch] = data;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!busy_n);
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk); load_n = 1'b0;
        @(negedge clk); load_n = 1'b1;
    endtask

    // driver side: model a load and push expected items
    task automatic model_load();
        exp_mask = '0;
        for (int c = 0; c < N; c++) begin
            if (calc(c) != exp_out[c]) exp_mask[c] = 1'b1;
            exp_out[c] = calc(c);
        end
    endtask

    task automatic push_all(string tag);
        for (int c = 0; c < N; c++) sb.push_back('{c, exp_out[c], tag});
    endtask

    // monitor side: pop and compare against the ports
    task automatic drain();
        while (sb.size() > 0) begin
            item_t it;
            int act;
            it = sb.pop_front();
            act = int'(out_code[it.ch*DW +: DW]);
            chk(act == it.code, it.tag, act, it.code);
        end
    endtask

    task automatic load_and_check(string tag);
        upd_seen = '0;
        pulse_load();
        repeat (2) @(negedge clk);
        model_load();
        push_all(tag);
        drain();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            mx1[c] = 8192; mg[c] = 8191; mo[c] = 8192; exp_out[c] = 8192;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        push_all("R1 reset code"); drain();
        chk(out_clr == '1, "R1 clr after reset", int'(out_clr), 15);
        chk(busy_n == 1'b1, "R1 busy idle", int'(busy_n), 1);

        // R5 busy timing, R3 identity with reset gain/offset
        wr(0, 0, 16'h1000);
        chk(busy_n == 1'b0, "R5 busy after write", int'(busy_n), 0);
        repeat (2) @(negedge clk);
        chk(busy_n == 1'b0, "R5 busy during calc", int'(busy_n), 0);
        @(negedge clk);
        chk(busy_n == 1'b1, "R5 busy released", int'(busy_n), 1);
        load_and_check("R3 identity");
        chk(out_clr == '0, "R9 clr dropped on load", int'(out_clr), 0);
        chk(upd_seen == exp_mask, "R8 only changed ch0", int'(upd_seen), int'(exp_mask));

        // R11 no load, no change
        wr(0, 1, 256);
        wait_idle();
        chk(int'(out_code[1*DW +: DW]) == 8192, "R11 held without load",
            int'(out_code[1*DW +: DW]), 8192);
        load_and_check("R3 ch1 load");
        chk(upd_seen == exp_mask, "R8 only changed ch1", int'(upd_seen), int'(exp_mask));

        // R3 gain and offset
        wr(1, 2, 4095);
        wr(2, 2, 8292);
        wait_idle();
        load_and_check("R3 gain/offset");
        chk(exp_out[2] == 4196, "R3 model sanity", exp_out[2], 4196);

        // R4 saturation both ends
        wr(2, 3, 16383);
        wr(0, 3, 12288);
        wr(2, 0, 0);
        wait_idle();
        load_and_check("R4 saturation");
        chk(int'(out_code[3*DW +: DW]) == 16383, "R4 clamp high",
            int'(out_code[3*DW +: DW]), 16383);
        chk(int'(out_code[0 +: DW]) == 0, "R4 clamp low", int'(out_code[0 +: DW]), 0);

        // R2 ignored selector
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_ch = 2'd1; wr_data = '0;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy_n == 1'b1, "R2 no calc started", int'(busy_n), 1);
        load_and_check("R2 ignored write");
        chk(upd_seen == '0, "R2 nothing rewritten", int'(upd_seen), 0);

        // R6 load edge during busy is remembered
        wr(0, 1, 512);
        pulse_load();
        chk(int'(out_code[1*DW +: DW]) == 256, "R6 not yet loaded",
            int'(out_code[1*DW +: DW]), 256);
        wait_idle();
        model_load(); push_all("R6 deferred load"); drain();

        // R10 external busy delays load
        busy_ext_n = 1'b0;
        wr(0, 1, 768);
        wait_idle();
        pulse_load();
        repeat (3) @(negedge clk);
        chk(int'(out_code[1*DW +: DW]) == 512, "R10 held by ext busy",
            int'(out_code[1*DW +: DW]), 512);
        busy_ext_n = 1'b1;
        repeat (2) @(negedge clk);
        model_load(); push_all("R10 after release"); drain();

        // R7 load held low
        @(negedge clk); load_n = 1'b0;
        wr(0, 2, 16'h1000);
        wait_idle();
        model_load(); push_all("R7 level load 1"); drain();
        chk(exp_out[2] == 2148, "R7 model sanity", exp_out[2], 2148);
        wr(0, 2, 16'h0800);
        wait_idle();
        model_load(); push_all("R7 level load 2"); drain();
        @(negedge clk); load_n = 1'b1;

        // R9 clear
        @(negedge clk); clr_n = 1'b0;
        @(negedge clk);
        chk(out_clr == '1, "R9 clear forced", int'(out_clr), 15);
        pulse_load();
        wr(2, 0, 8192);
        wait_idle();
        clr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_clr == '1, "R9 stays cleared", int'(out_clr), 15);
        chk(int'(out_code[0 +: DW]) == 0, "R9 load ignored in clear",
            int'(out_code[0 +: DW]), 0);
        load_and_check("R9 load after clear");
        chk(out_clr == '0, "R9 released by load", int'(out_clr), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule